// File: doc/BRIEF.md
# Keyed Factory-Restore Erase Sequencer

This block returns a device to its blank state, but only after software or a debug agent has written a three-word unlock key that exactly matches a built-in constant. The key words are written through a small write-only register port. A write to the launch address then compares all three words at once. If the key is accepted, the block drives a fixed chain of six operations. Each operation is a request/acknowledge exchange with an external agent that does the real erase or register write. The chain erases the low-power domain RAM, then the system SRAM, then opens the flash protection, erases the EEPROM, mass-erases the flash and rewrites the boot configuration.

When the last operation is acknowledged, the block zeroes a 24-bit completion field to mark success and raises a system-reset output for a fixed number of cycles. A launch with a wrong key starts nothing. It only sets a sticky error flag. Every launch attempt, whether accepted or rejected, consumes the stored key words. A later attempt therefore needs a full rewrite of the key.

Top module: `factory_restore_seq`

## Requirements
- R1: A write with `cfg_wr_addr` 0, 1 or 2 stores `cfg_wr_data` as key word 0, 1 or 2. A write to address 3 is a launch, and it compares the stored words against 0x02010100 (word 0), 0x0D080503 (word 1) and 0x59372215 (word 2).
- R2: On a matching launch, the block issues exactly six steps in this order, with `step_req` bit 0 first: bit 0 erases the low-power domain RAM, bit 1 the system SRAM, bit 2 writes the flash-protection registers, bit 3 erases the EEPROM pages, bit 4 mass-erases the flash and bit 5 writes the boot configuration. The first request is visible in the cycle after the launch write.
- R3: Exactly one bit of `step_req` is high at a time. It holds steady until the matching bit of `step_ack` is sampled high. Acknowledge bits that do not match the current request have no effect.
- R4: `step_wdata` is 0xFFFFFFFF during step bit 2, 0xFFFFFFFE during step bit 5, and zero otherwise.
- R5: `done_code` resets to all ones. It is set to all ones again on an accepted launch, and it becomes 0x000000 at the clock edge that samples the last acknowledge.
- R6: `sys_rst` goes high in the cycle after the last acknowledge and stays high for exactly 4 cycles.
- R7: `busy` is high from the cycle after an accepted launch through the last `sys_rst` cycle, and it is low once the pulse ends.
- R8: A launch with any key word wrong issues no request, leaves `busy` low and sets `key_err`. `key_err` then stays high until `rst_n` is asserted.
- R9: Key writes and launches made while `busy` is high are ignored.
- R10: `rst_n` and every launch attempt clear all three stored key words to zero.
- R11: After reset, `busy`, `key_err`, `sys_rst` and `step_req` are low and `done_code` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | ADDR_W (2) | 0..2 key word, 3 launch |
| cfg_wr_data | input | 32 | Write data |
| step_req | output | 6 | One-hot operation request |
| step_ack | input | 6 | Per-operation acknowledge |
| step_wdata | output | 32 | Value to write for the current operation |
| busy | output | 1 | Restore in progress |
| key_err | output | 1 | Sticky rejected-key flag |
| done_code | output | STATUS_W (24) | Completion field, zero on success |
| sys_rst | output | 1 | System reset pulse |

## Verification
A wrong step index shows at the ports in the cycle it happens. The request bit or the write value no longer matches the next item the scoreboard expects. An early or late advance shows as a request that changes before its acknowledge, or as extra or missing steps. A fault in the key bank or the pulse counter shows within a few cycles of the launch, or at the falling edge of `sys_rst`. It appears as a run that should not have started, a missing `key_err`, or a reset pulse whose length is not 4.

// File: rtl/frs_pkg.sv
package frs_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned KEY_N  = 3;
   localparam int unsigned STEP_N = 6;

   typedef logic [WORD_W-1:0] word_t;

   localparam word_t UNLOCK_KEY [KEY_N] = '{32'h0201_0100, 32'h0D08_0503, 32'h5937_2215};

   // value presented with each step; only the register-write steps carry data
   function automatic word_t step_payload(int idx);
      case (idx)
         2:       return 32'hFFFF_FFFF;
         5:       return 32'hFFFF_FFFE;
         default: return '0;
      endcase
   endfunction
endpackage

// File: rtl/frs_key_bank.sv
module frs_key_bank
   import frs_pkg::*;
#(
   parameter int unsigned ADDR_W = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  word_t             wr_data,
   input  logic              lock,
   output logic              accept,
   output logic              key_err
);
   word_t            key_q [KEY_N];
   logic [KEY_N-1:0] hit;
   logic             launch;

   assign launch = wr_en && !lock && (wr_addr == ADDR_W'(KEY_N));

   for (genvar k = 0; k < KEY_N; k++) begin : g_key
      always_ff @(posedge clk) begin
         if (!rst_n || launch)
            key_q[k] <= '0;
         else if (wr_en && !lock && (wr_addr == ADDR_W'(k)))
            key_q[k] <= wr_data;
      end
      assign hit[k] = (key_q[k] == UNLOCK_KEY[k]);
   end

   assign accept = launch && (&hit);

   always_ff @(posedge clk) begin
      if (!rst_n)
         key_err <= 1'b0;
      else if (launch && !(&hit))
         key_err <= 1'b1;
   end

   // R8: a rejected launch raises the flag, and it never drops without reset
   p_reject_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !(&hit)) |=> key_err);
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      key_err |=> key_err);
   // R10: a launch consumes the stored key
   p_key_consumed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (key_q[0] == '0));
   // R9: locked writes leave the key untouched
   p_lock_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(key_q[0]));
endmodule

// File: rtl/frs_step_seq.sv
module frs_step_seq
   import frs_pkg::*;
#(
   parameter int unsigned STEPS = STEP_N
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [STEPS-1:0] step_ack,
   output logic [STEPS-1:0] step_req,
   output word_t            step_wdata,
   output logic             active,
   output logic             last_done
);
   localparam int unsigned IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;

   logic [IDX_W-1:0] idx_q;
   logic             take;

   assign take      = active && (|(step_ack & step_req));
   assign last_done = take && (idx_q == IDX_W'(STEPS-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx_q  <= '0;
      end else if (start && !active) begin
         active <= 1'b1;
         idx_q  <= '0;
      end else if (take) begin
         if (idx_q == IDX_W'(STEPS-1)) begin
            active <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < STEPS; g++) begin : g_req
      assign step_req[g] = active && (idx_q == IDX_W'(g));
   end

   always_comb begin
      step_wdata = '0;
      for (int i = 0; i < STEPS; i++)
         if (step_req[i]) step_wdata = step_wdata | step_payload(i);
   end

   // R3: one request at a time, held until its own acknowledge
   p_req_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(step_req));
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|step_req) && !(|(step_ack & step_req))) |=> (step_req == $past(step_req)));
   // R2: a new run always opens on the first step
   p_first_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !active) |=> step_req[0]);
endmodule

// File: rtl/frs_reset_pulse.sv
module frs_reset_pulse #(
   parameter int unsigned PULSE_CYC = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);
   localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (fire)
         cnt_q <= CNT_W'(PULSE_CYC);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign pulse = (cnt_q != '0);

   // R6: the counter never exceeds the programmed length
   p_cnt_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(PULSE_CYC));
   p_fire_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> pulse);
endmodule

// File: rtl/factory_restore_seq.sv
module factory_restore_seq
   import frs_pkg::*;
#(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned STATUS_W  = 24,
   parameter int unsigned PULSE_CYC = 4
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr_en,
   input  logic [ADDR_W-1:0]   cfg_wr_addr,
   input  logic [WORD_W-1:0]   cfg_wr_data,
   output logic [STEP_N-1:0]   step_req,
   input  logic [STEP_N-1:0]   step_ack,
   output logic [WORD_W-1:0]   step_wdata,
   output logic                busy,
   output logic                key_err,
   output logic [STATUS_W-1:0] done_code,
   output logic                sys_rst
);
   if (ADDR_W < $clog2(KEY_N + 1)) begin : g_chk_addr
      $error("ADDR_W too narrow for key words plus launch address");
   end
   if (PULSE_CYC < 1) begin : g_chk_pulse
      $error("PULSE_CYC must be at least 1");
   end
   if (STATUS_W < 1) begin : g_chk_status
      $error("STATUS_W must be at least 1");
   end

   logic accept, seq_active, last_done;

   frs_key_bank #(.ADDR_W(ADDR_W)) u_keys (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_addr (cfg_wr_addr),
      .wr_data (cfg_wr_data),
      .lock    (busy),
      .accept  (accept),
      .key_err (key_err)
   );

   frs_step_seq #(.STEPS(STEP_N)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .step_ack   (step_ack),
      .step_req   (step_req),
      .step_wdata (step_wdata),
      .active     (seq_active),
      .last_done  (last_done)
   );

   frs_reset_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (last_done),
      .pulse (sys_rst)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || accept)
         done_code <= '1;
      else if (last_done)
         done_code <= '0;
   end

   assign busy = seq_active || sys_rst;

   // R5: the completion field reads zero whenever the reset pulse begins
   p_status_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> (done_code == '0));
   // R6: the last acknowledge is followed by the reset pulse
   p_last_fires_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req[STEP_N-1] && step_ack[STEP_N-1]) |=> sys_rst);
   // R7: requests only appear while busy, and busy drops with the pulse
   p_req_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|step_req) |-> busy);
   p_busy_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst) |-> !busy);
endmodule

// File: tb/tb_factory_restore_seq.sv
module tb_factory_restore_seq;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] K0 = 32'h0201_0100;
   localparam logic [31:0] K1 = 32'h0D08_0503;
   localparam logic [31:0] K2 = 32'h5937_2215;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr_en;
   logic [1:0]  cfg_wr_addr;
   logic [31:0] cfg_wr_data;
   logic [5:0]  step_req;
   logic [5:0]  step_ack;
   logic [31:0] step_wdata;
   logic        busy, key_err, sys_rst;
   logic [23:0] done_code;

   always #(CLK_PERIOD/2) clk = ~clk;

   factory_restore_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
      .cfg_wr_data(cfg_wr_data), .step_req(step_req), .step_ack(step_ack),
      .step_wdata(step_wdata), .busy(busy), .key_err(key_err),
      .done_code(done_code), .sys_rst(sys_rst)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int ack_delay = 0;
   bit stray_ack = 0;
   int pulses_seen = 0;

   typedef struct { int idx; logic [31:0] data; } step_item_t;
   step_item_t exp_q [$];

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic write_word(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   // driver: expected step items of one full restore
   task automatic push_run();
      for (int i = 0; i < 6; i++) begin
         step_item_t it;
         it.idx  = i;
         it.data = (i == 2) ? 32'hFFFF_FFFF : (i == 5) ? 32'hFFFF_FFFE : 32'h0;
         exp_q.push_back(it);
      end
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   // monitor / acknowledge agent
   initial begin
      step_ack = '0;
      forever begin
         logic [5:0] seen;
         step_item_t it;
         @(negedge clk);
         if (step_req != '0) begin
            seen = step_req;
            for (int w = 0; w < ack_delay; w++) begin
               @(negedge clk);
               check(step_req == seen, "R3 request held", {26'b0, step_req}, {26'b0, seen});
            end
            if (stray_ack) begin
               stray_ack = 0;
               step_ack = ~seen;
               @(negedge clk);
               step_ack = '0;
               check(step_req == seen, "R3 stray ack ignored", {26'b0, step_req}, {26'b0, seen});
            end
            if (exp_q.size() == 0) begin
               check(1'b0, "R9/R8 unexpected request", {26'b0, seen}, 32'h0);
            end else begin
               it = exp_q.pop_front();
               check(seen == (6'b1 << it.idx), "R2 step order", {26'b0, seen}, 32'(6'b1 << it.idx));
               check(step_wdata == it.data, "R4 step data", step_wdata, it.data);
            end
            step_ack = seen;
            @(negedge clk);
            step_ack = '0;
         end
      end
   end

   // reset-pulse monitor
   initial begin
      int plen = 0;
      forever begin
         @(negedge clk);
         if (sys_rst) begin
            plen++;
         end else if (plen != 0) begin
            check(plen == 4, "R6 pulse length", 32'(plen), 32'd4);
            check(!busy, "R7 busy low after pulse", {31'b0, busy}, 32'd0);
            check(done_code == 24'h0, "R5 done code cleared", {8'b0, done_code}, 32'h0);
            pulses_seen++;
            plen = 0;
         end
      end
   end

   task automatic finish_test();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_test();
   end

   initial begin
      int p0;
      rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(!busy && !key_err && !sys_rst && step_req == 0, "R11 reset outputs",
            {26'b0, step_req}, 32'h0);
      check(done_code == 24'hFFFFFF, "R11 done code at reset", {8'b0, done_code}, 32'hFFFFFF);

      // run A: R1 R2 acknowledges without delay
      ack_delay = 0;
      push_run();
      write_word(0, K0); write_word(1, K1); write_word(2, K2); write_word(3, 32'h0);
      check(busy, "R7 busy after accept", {31'b0, busy}, 32'd1);
      wait_idle();
      check(exp_q.size() == 0, "R2 all steps issued", 32'(exp_q.size()), 32'd0);
      check(pulses_seen == 1, "R6 one pulse", 32'(pulses_seen), 32'd1);
      check(!key_err, "R8 no error on good key", {31'b0, key_err}, 32'd0);

      // run B: delayed acks, writes during busy must be ignored (R9)
      ack_delay = 2;
      push_run();
      write_word(2, K2); write_word(1, K1); write_word(0, K0); write_word(3, 32'h0);
      check(done_code == 24'hFFFFFF, "R5 done code set on accept", {8'b0, done_code}, 32'hFFFFFF);
      write_word(0, K0);
      write_word(3, 32'h0);
      wait_idle();
      repeat (3) @(negedge clk);
      check(pulses_seen == 2, "R9 no second run from busy launch", 32'(pulses_seen), 32'd2);

      // R10/R9: key 0 was consumed and not rewritten while busy, so this launch fails
      write_word(1, K1); write_word(2, K2); write_word(3, 32'h0);
      repeat (6) @(negedge clk);
      check(!busy && step_req == 0, "R10 consumed key rejected", {31'b0, busy}, 32'd0);
      check(key_err, "R8 key error set", {31'b0, key_err}, 32'd1);

      // reset clears the flag, then a single bad word is rejected
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(!key_err, "R8 error cleared by reset", {31'b0, key_err}, 32'd0);
      write_word(0, K0); write_word(1, K1 ^ 32'h100); write_word(2, K2); write_word(3, 32'h0);
      repeat (6) @(negedge clk);
      check(key_err && !busy, "R8 wrong word 1 rejected", {31'b0, key_err}, 32'd1);
      check(done_code == 24'hFFFFFF, "R8 no completion on bad key", {8'b0, done_code}, 32'hFFFFFF);

      // run C: stray acknowledge on another bit, sticky error persists
      ack_delay = 1;
      stray_ack = 1;
      p0 = pulses_seen;
      push_run();
      write_word(0, K0); write_word(1, K1); write_word(2, K2); write_word(3, 32'h0);
      wait_idle();
      check(pulses_seen == p0 + 1, "R1 good key after bad one runs", 32'(pulses_seen), 32'(p0 + 1));
      check(key_err, "R8 error sticky through run", {31'b0, key_err}, 32'd1);
      check(exp_q.size() == 0, "R3 run complete after stray ack", 32'(exp_q.size()), 32'd0);
      repeat (4) @(negedge clk);
      finish_test();
   end
endmodule